// File: doc/BRIEF.md
# Return-From-Exception Status Unwinder

This block carries out the status-register side of leaving an exception handler. The 32-bit status word holds a stack of mode-bit groups. A return pops that stack with a masked right shift by ten places, which moves the saved group into the live position. The two top bits stay where they are.

After the pop, two flag rules apply. The P flag is raised only if the R flag was clear in the word as it stood before the pop. An NMI-style return also always raises the M flag. If the popped word selects user mode, the stack pointer is swapped: the current SP is kept as the kernel SP, and SP is reloaded from the user copy.

A request arrives on a valid/ready input carrying the return kind, the status, SP and USP. The result leaves on a valid/ready output as the new status, the new SP and the held kernel SP. The block accepts a new request when its output register is empty, or when that register is being drained in the same cycle. While the consumer holds `res_ready` low, the result stays on the outputs unchanged and `req_ready` is low.

Top module: `rfe_unwinder`

## Requirements
- R1: After reset `res_valid` is 0 and `res_status`, `res_sp` and `res_ksp` are all zero.
- R2: The result status is built as follows. Bits 31:30 are copied from the request status. Bits 17:0 take request bits 27:10. Bits 29:18 are zero. The P flag (bit 7) and the M flag (bit 30) are the exceptions, set as R3 and R4 describe.
- R3: If the request status has the R flag (bit 8) clear, the result has P (bit 7) set. If R is set, P is the value the pop placed there, which is request bit 17.
- R4: For `req_kind` = 1 (NMI return), the result always has M (bit 30) set.
- R5: For `req_kind` = 0 (exception return), result bit 30 equals request bit 30.
- R6: If the popped status has U (bit 6, taken from request bit 16) set, `res_sp` becomes `req_usp` and `res_ksp` becomes `req_sp`.
- R7: If the popped status has U clear, `res_sp` becomes `req_sp` and `res_ksp` keeps its previous value.
- R8: A request accepted at a clock edge (`req_valid` and `req_ready` both high) produces `res_valid` high, with its result, right after that same edge.
- R9: While `res_valid` is high and `res_ready` is low, `req_ready` is low and all result outputs and `res_valid` hold.
- R10: When no request is accepted, the result registers hold their values. `res_valid` falls after a cycle with `res_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 1 | 0 = exception return, 1 = NMI return |
| req_status | input | 32 | Status word before the return |
| req_sp | input | 32 | Current stack pointer |
| req_usp | input | 32 | User stack pointer copy |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_status | output | 32 | Status after the pop and flag rules |
| res_sp | output | 32 | Stack pointer after the return |
| res_ksp | output | 32 | Saved kernel stack pointer |

## Verification
Each result sits behind exactly one register. An accepted request is therefore due on the outputs in the cycle after its acceptance edge, and the bench reads it half a period later. The driver records the expected item only once it has seen `req_ready` high at the falling edge before the accepting edge. The monitor pops that item at the first falling edge where both `res_valid` and `res_ready` are high. Whenever the consumer stalls, the stalled outputs are snapshotted and compared again one cycle later.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  typedef enum logic {
    RET_EXC = 1'b0,
    RET_NMI = 1'b1
  } ret_kind_e;
endpackage

// File: rtl/rfe_pop.sv
module rfe_pop #(
  parameter int DATA_W  = 32,
  parameter int KEEP_HI = 2,
  parameter int POP_MSB = 27,
  parameter int SHIFT   = 10
) (
  input  logic [DATA_W-1:0] st_in,
  output logic [DATA_W-1:0] st_pop
);
  localparam int KEEP_LO = DATA_W - KEEP_HI;

  logic unused_st;
  assign unused_st = ^st_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i >= KEEP_LO) begin : g_keep
      assign st_pop[i] = st_in[i];
    end else if (i + SHIFT <= POP_MSB) begin : g_move
      assign st_pop[i] = st_in[i+SHIFT];
    end else begin : g_zero
      assign st_pop[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rfe_flag_fix.sv
module rfe_flag_fix
  import rfe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int P_POS  = 7,
  parameter int M_POS  = 30
) (
  input  logic [DATA_W-1:0] st_pop,
  input  logic              r_before,
  input  ret_kind_e         kind,
  output logic [DATA_W-1:0] st_fix
);
  always_comb begin
    st_fix = st_pop;
    if (!r_before) st_fix[P_POS] = 1'b1;
    if (kind == RET_NMI) st_fix[M_POS] = 1'b1;
  end
endmodule

// File: rtl/rfe_sp_sel.sv
module rfe_sp_sel #(
  parameter int ADDR_W = 32
) (
  input  logic              to_user,
  input  logic [ADDR_W-1:0] sp_cur,
  input  logic [ADDR_W-1:0] sp_user,
  output logic [ADDR_W-1:0] sp_next,
  output logic              ksp_load
);
  assign sp_next  = to_user ? sp_user : sp_cur;
  assign ksp_load = to_user;
endmodule

// File: rtl/rfe_unwinder.sv
module rfe_unwinder
  import rfe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int KEEP_HI = 2,
  parameter int POP_MSB = 27,
  parameter int SHIFT   = 10,
  parameter int U_POS   = 6,
  parameter int P_POS   = 7,
  parameter int R_POS   = 8,
  parameter int M_POS   = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_kind,
  input  logic [DATA_W-1:0] req_status,
  input  logic [ADDR_W-1:0] req_sp,
  input  logic [ADDR_W-1:0] req_usp,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_status,
  output logic [ADDR_W-1:0] res_sp,
  output logic [ADDR_W-1:0] res_ksp
);
  logic [DATA_W-1:0] st_pop;
  logic [DATA_W-1:0] st_fix;
  logic [ADDR_W-1:0] sp_next;
  logic              ksp_load;
  logic              accept;
  ret_kind_e         kind;

  assign kind      = ret_kind_e'(req_kind);
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  rfe_pop #(
    .DATA_W (DATA_W),
    .KEEP_HI(KEEP_HI),
    .POP_MSB(POP_MSB),
    .SHIFT  (SHIFT)
  ) u_pop (
    .st_in (req_status),
    .st_pop(st_pop)
  );

  rfe_flag_fix #(
    .DATA_W(DATA_W),
    .P_POS (P_POS),
    .M_POS (M_POS)
  ) u_fix (
    .st_pop  (st_pop),
    .r_before(req_status[R_POS]),
    .kind    (kind),
    .st_fix  (st_fix)
  );

  rfe_sp_sel #(
    .ADDR_W(ADDR_W)
  ) u_sp (
    .to_user (st_pop[U_POS]),
    .sp_cur  (req_sp),
    .sp_user (req_usp),
    .sp_next (sp_next),
    .ksp_load(ksp_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_status <= '0;
      res_sp     <= '0;
      res_ksp    <= '0;
    end else begin
      if (accept) begin
        res_status <= st_fix;
        res_sp     <= sp_next;
        if (ksp_load) res_ksp <= req_sp;
      end
      if (accept) res_valid <= 1'b1;
      else if (res_ready) res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rfe_unwinder_chk.sv
module rfe_unwinder_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int SHIFT   = 10,
  parameter int U_POS   = 6,
  parameter int P_POS   = 7,
  parameter int R_POS   = 8,
  parameter int M_POS   = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_kind,
  input logic [DATA_W-1:0] req_status,
  input logic [ADDR_W-1:0] req_sp,
  input logic [ADDR_W-1:0] req_usp,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_status,
  input logic [ADDR_W-1:0] res_sp,
  input logic [ADDR_W-1:0] res_ksp
);
  localparam int U_SRC = U_POS + SHIFT;

  logic acc;
  assign acc = req_valid && req_ready;

  // R8
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_status) &&
                                   $stable(res_sp) && $stable(res_ksp)));

  // R3
  p_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_status[R_POS]) |=> res_status[P_POS]);

  // R4
  nmi_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind) |=> res_status[M_POS]);

  // R6
  user_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_status[U_SRC]) |=> (res_sp == $past(req_usp) &&
                                     res_ksp == $past(req_sp)));

  // R7
  ksp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_status[U_SRC]) |=> (res_sp == $past(req_sp) && $stable(res_ksp)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(res_status) && $stable(res_sp) && $stable(res_ksp)));
endmodule

bind rfe_unwinder rfe_unwinder_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .SHIFT (SHIFT),
  .U_POS (U_POS),
  .P_POS (P_POS),
  .R_POS (R_POS),
  .M_POS (M_POS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_status(req_status),
  .req_sp    (req_sp),
  .req_usp   (req_usp),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_status(res_status),
  .res_sp    (res_sp),
  .res_ksp   (res_ksp)
);

// File: tb/rfe_unwinder_bench.sv
module rfe_unwinder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_kind = 1'b0;
  logic [31:0] req_status = '0;
  logic [31:0] req_sp = '0;
  logic [31:0] req_usp = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_status;
  logic [31:0] res_sp;
  logic [31:0] res_ksp;

  int n_chk = 0;
  int n_bad = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  logic [31:0] model_ksp = '0;
  logic [31:0] last_st = '0, last_sp = '0, last_ksp = '0;
  // entry: {user, kind, status, sp, ksp}
  logic [97:0] sb_q[$];

  always #2.5 clk = ~clk;

  rfe_unwinder u_rfe_unwinder (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_status(req_status), .req_sp(req_sp), .req_usp(req_usp),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_status(res_status), .res_sp(res_sp), .res_ksp(res_ksp)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_status(logic k, logic [31:0] s);
    logic [31:0] r;
    r = {s[31:30], 12'b0, s[27:10]};
    if (!s[8]) r[7] = 1'b1;
    if (k) r[30] = 1'b1;
    return r;
  endfunction

  task automatic send(logic k, logic [31:0] s, logic [31:0] sp, logic [31:0] usp);
    logic u;
    logic [31:0] esp;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_status = s; req_sp = sp; req_usp = usp;
    while (!req_ready) @(negedge clk);
    u = s[16];
    if (u) begin esp = usp; model_ksp = sp; end
    else esp = sp;
    sb_q.push_back({u, k, model_status(k, s), esp, model_ksp});
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 res_valid after accept", {31'b0, res_valid}, 32'd1);
  endtask

  always @(posedge clk) begin
    #1 res_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
  end

  bit prev_stall = 1'b0;
  logic [31:0] snap_st, snap_sp, snap_ksp;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk("R9 status held", res_status, snap_st);
        chk("R9 sp held", res_sp, snap_sp);
        chk("R9 ksp held", res_ksp, snap_ksp);
        chk("R9 valid held", {31'b0, res_valid}, 32'd1);
      end
      prev_stall = res_valid && !res_ready;
      if (prev_stall) begin
        snap_st = res_status; snap_sp = res_sp; snap_ksp = res_ksp;
        chk("R9 req_ready low in stall", {31'b0, req_ready}, 32'd0);
      end
      if (res_valid && res_ready) begin
        if (sb_q.size() == 0) begin
          chk("R8 unexpected result", 32'd1, 32'd0);
        end else begin
          logic [97:0] e;
          e = sb_q.pop_front();
          chk("R2 popped field", res_status & ~32'h4000_0080, e[95:64] & ~32'h4000_0080);
          chk("R3 P flag", {31'b0, res_status[7]}, {31'b0, e[71]});
          if (e[96]) chk("R4 M flag on NMI return", {31'b0, res_status[30]}, 32'd1);
          else chk("R5 M flag on exception return", {31'b0, res_status[30]}, {31'b0, e[94]});
          if (e[97]) begin
            chk("R6 sp from usp", res_sp, e[63:32]);
            chk("R6 ksp saved", res_ksp, e[31:0]);
          end else begin
            chk("R7 sp kept", res_sp, e[63:32]);
            chk("R7 ksp unchanged", res_ksp, e[31:0]);
          end
          last_st = res_status; last_sp = res_sp; last_ksp = res_ksp;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid after reset", {31'b0, res_valid}, 32'd0);
    chk("R1 status after reset", res_status, 32'd0);
    chk("R1 sp after reset", res_sp, 32'd0);
    chk("R1 ksp after reset", res_ksp, 32'd0);
    rst_n = 1'b1;
    // directed corners
    send(1'b0, 32'h0000_0100, 32'h1111_0000, 32'h2222_0000); // R set, no P
    send(1'b0, 32'h0000_0000, 32'h1111_0004, 32'h2222_0004); // P from R clear
    send(1'b1, 32'h0001_0000, 32'h3333_0000, 32'h4444_0000); // NMI + user swap
    send(1'b0, 32'hC000_0000, 32'h5555_0000, 32'h6666_0000); // R5 top bits kept
    send(1'b0, 32'hFFFF_FFFF, 32'h7777_0000, 32'h8888_0000); // all ones
    send(1'b1, 32'h3FFE_FEFF, 32'h9999_0000, 32'hAAAA_0000); // gap cleared
    repeat (3) @(negedge clk);
    // R10 idle hold
    chk("R10 valid drops when idle", {31'b0, res_valid}, 32'd0);
    chk("R10 status held idle", res_status, last_st);
    chk("R10 sp held idle", res_sp, last_sp);
    chk("R10 ksp held idle", res_ksp, last_ksp);
    // random traffic with back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send(1'($urandom), $urandom, $urandom, $urandom);
    end
    stall_en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 scoreboard drained", sb_q.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule